// File: doc/BRIEF.md
# Four-Channel DMA Control and Request Scanner

This block is the control section of a four-channel DMA controller. Software reaches it through eight write-only control ports that set the command, post or withdraw a software request, change one channel's mask or all of them, store a channel's mode byte, clear the byte-pointer flip-flop, or reset the controller. The block holds a shared status byte: the upper half is the per-channel request flags and the lower half is the per-channel terminal-count flags. It also holds the mask, the command and four mode registers.

Each channel's device can hold or release its request. The address/count datapath, which lives outside this block, reports terminal counts and byte-pointer accesses. A service pass is started with one strobe. It visits channels 0 to 3 in turn, one per cycle, and emits a one-cycle service strobe to every channel that is unmasked and requesting at the moment it is visited. A start that arrives while a pass is running is refused and flagged.

Top module: `dmac_ctrl`

## Requirements
- R1: After reset all four mask bits are 1. The status byte, command, flip-flop and all mode registers are 0, no service strobe is active and no pass is running.
- R2: A write to port code 0 with data 0 stores 0 as the command. Any other data leaves the command unchanged and pulses `cmd_err_o` for exactly the cycle after the write.
- R3: A write to port code 1 selects the channel with data bits 1:0. It writes data bit 2 into status bit (channel+4), the request flag, and clears status bit (channel), the terminal-count flag.
- R4: A write to port code 2 sets mask bit (data bits 1:0) when data bit 2 is 1 and clears it when data bit 2 is 0. The other data bits have no effect.
- R5: A write to port code 3 stores the whole data byte as the mode of the channel named by data bits 1:0. `mode_o` holds channel k in bits 8k+7:8k.
- R6: A pulse on `ff_toggle_i` inverts the flip-flop. A write to port code 4 forces it to 0, and this takes priority over a toggle in the same cycle.
- R7: A write to port code 5 sets all mask bits to 1 and clears the status byte, command and flip-flop. The mode registers are left unchanged.
- R8: A write to port code 6 clears all mask bits. A write to port code 7 loads the mask from data bits 3:0.
- R9: `hold_i[k]` sets request flag k and `release_i[k]` clears it. `tc_i[k]` sets terminal-count flag k. These device events are applied after any port write in the same cycle, and a release wins over a hold.
- R10: When `scan_start_i` is seen while idle, `scan_busy_o` is high for the next four cycles, and channel k is visited in the (k+1)th of them. Channel k's strobe `svc_o[k]` appears in the cycle after its visit, and only if mask bit k was 0 and request flag k was 1 at the visit.
- R11: When `scan_start_i` is seen while a pass is running, `scan_reject_o` pulses for one cycle and the running pass continues unchanged.
- R12: At most one bit of `svc_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control port write strobe |
| wr_port_i | input | 3 | Control port code (0 to 7) |
| wr_data_i | input | 8 | Control port write data |
| hold_i | input | 4 | Per-channel device request hold |
| release_i | input | 4 | Per-channel device request release |
| tc_i | input | 4 | Per-channel terminal-count report from the datapath |
| ff_toggle_i | input | 1 | Byte-pointer access from the datapath |
| scan_start_i | input | 1 | Start a service pass |
| status_o | output | 8 | Request flags (7:4) and terminal-count flags (3:0) |
| mask_o | output | 4 | Channel mask bits |
| command_o | output | 8 | Command register |
| ff_o | output | 1 | Byte-pointer flip-flop |
| mode_o | output | 32 | Mode bytes of channels 3..0 |
| svc_o | output | 4 | Per-channel service strobe |
| scan_busy_o | output | 1 | A service pass is running |
| scan_reject_o | output | 1 | A start was refused during a pass |
| cmd_err_o | output | 1 | Unsupported command pulse |

## Verification
The hardest case to reach from the ports is a second start arriving while a pass is already running. The bench has to show two things in that case: the start is refused, and the pass it interrupted still strobes the right channels at the right cycles. To get there, the bench raises the start a second time two cycles into a pass, then keeps checking the strobes cycle by cycle until the pass ends. It also drives a same-cycle hold and release, and a toggle together with a flip-flop clear, to pin down the stated priorities.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    PORT_CMD     = 3'd0,
    PORT_REQ     = 3'd1,
    PORT_SMASK   = 3'd2,
    PORT_MODE    = 3'd3,
    PORT_CLRFF   = 3'd4,
    PORT_MRST    = 3'd5,
    PORT_CLRMASK = 3'd6,
    PORT_WRMASK  = 3'd7
  } ctl_port_e;

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_port_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [NCH-1:0]    hold_i,
  input  logic [NCH-1:0]    release_i,
  input  logic [NCH-1:0]    tc_i,
  input  logic              ff_toggle_i,
  output logic [2*NCH-1:0]  status_o,
  output logic [NCH-1:0]    mask_o,
  output logic [DW-1:0]     command_o,
  output logic              ff_o,
  output logic [NCH*DW-1:0] mode_o,
  output logic              cmd_err_o
);

  localparam int CW      = $clog2(NCH);
  localparam int SET_BIT = CW;

  ctl_port_e           port;
  logic [CW-1:0]       sel;
  logic [2*NCH-1:0]    stat_q, stat_d;
  logic [NCH-1:0]      mask_q, mask_d;
  logic [DW-1:0]       cmd_q, cmd_d;
  logic                ff_q, ff_d;
  logic                err_q, err_d;
  logic                reg_en;

  assign port   = ctl_port_e'(wr_port_i);
  assign sel    = wr_data_i[CW-1:0];
  assign reg_en = wr_en_i | (|hold_i) | (|release_i) | (|tc_i) | ff_toggle_i;

  always_comb begin
    stat_d = stat_q;
    mask_d = mask_q;
    cmd_d  = cmd_q;
    ff_d   = ff_q ^ ff_toggle_i;
    err_d  = 1'b0;
    if (wr_en_i) begin
      case (port)
        PORT_CMD: begin
          if (wr_data_i == '0) cmd_d = '0;
          else                 err_d = 1'b1;
        end
        PORT_REQ: begin
          stat_d[NCH + int'(sel)] = wr_data_i[SET_BIT];
          stat_d[sel]             = 1'b0;
        end
        PORT_SMASK:   mask_d[sel] = wr_data_i[SET_BIT];
        PORT_CLRFF:   ff_d = 1'b0;
        PORT_MRST: begin
          mask_d = '1;
          stat_d = '0;
          cmd_d  = '0;
          ff_d   = 1'b0;
        end
        PORT_CLRMASK: mask_d = '0;
        PORT_WRMASK:  mask_d = wr_data_i[NCH-1:0];
        default: ;
      endcase
    end
    // device events land after the port write; release beats hold
    stat_d[NCH +: NCH] = (stat_d[NCH +: NCH] | hold_i) & ~release_i;
    stat_d[NCH-1:0]    = stat_d[NCH-1:0] | tc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
      cmd_q  <= '0;
      ff_q   <= 1'b0;
    end else if (reg_en) begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      cmd_q  <= cmd_d;
      ff_q   <= ff_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    logic          we;
    logic [DW-1:0] mode_q;
    assign we = wr_en_i && (port == PORT_MODE) && (sel == CW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mode_q <= '0;
      else if (we)  mode_q <= wr_data_i;
    end
    assign mode_o[g*DW +: DW] = mode_q;
  end

  assign status_o  = stat_q;
  assign mask_o    = mask_q;
  assign command_o = cmd_q;
  assign ff_o      = ff_q;
  assign cmd_err_o = err_q;

endmodule

// File: rtl/dmac_scan.sv
module dmac_scan #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [NCH-1:0] elig_i,
  output logic [NCH-1:0] svc_o,
  output logic           busy_o,
  output logic           reject_o
);

  localparam int CW = $clog2(NCH);
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic           busy_q, busy_d;
  logic [CW-1:0]  idx_q, idx_d;
  logic [NCH-1:0] svc_q, svc_d;
  logic           rej_q, rej_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    svc_d  = '0;
    rej_d  = start_i & busy_q;
    if (busy_q) begin
      if (elig_i[idx_q]) svc_d[idx_q] = 1'b1;
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      svc_q  <= '0;
      rej_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      svc_q  <= svc_d;
      rej_q  <= rej_d;
    end
  end

  assign svc_o    = svc_q;
  assign busy_o   = busy_q;
  assign reject_o = rej_q;

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_port_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [NCH-1:0]    hold_i,
  input  logic [NCH-1:0]    release_i,
  input  logic [NCH-1:0]    tc_i,
  input  logic              ff_toggle_i,
  input  logic              scan_start_i,
  output logic [2*NCH-1:0]  status_o,
  output logic [NCH-1:0]    mask_o,
  output logic [DW-1:0]     command_o,
  output logic              ff_o,
  output logic [NCH*DW-1:0] mode_o,
  output logic [NCH-1:0]    svc_o,
  output logic              scan_busy_o,
  output logic              scan_reject_o,
  output logic              cmd_err_o
);

  logic [NCH-1:0] elig;

  dmac_regs #(.NCH(NCH), .DW(DW)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_port_i   (wr_port_i),
    .wr_data_i   (wr_data_i),
    .hold_i      (hold_i),
    .release_i   (release_i),
    .tc_i        (tc_i),
    .ff_toggle_i (ff_toggle_i),
    .status_o    (status_o),
    .mask_o      (mask_o),
    .command_o   (command_o),
    .ff_o        (ff_o),
    .mode_o      (mode_o),
    .cmd_err_o   (cmd_err_o)
  );

  assign elig = ~mask_o & status_o[2*NCH-1:NCH];

  dmac_scan #(.NCH(NCH)) scan_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (scan_start_i),
    .elig_i   (elig),
    .svc_o    (svc_o),
    .busy_o   (scan_busy_o),
    .reject_o (scan_reject_o)
  );

endmodule

// File: rtl/dmac_ctrl_chk.sv
module dmac_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_port_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [NCH-1:0]   hold_i,
  input logic [NCH-1:0]   release_i,
  input logic [NCH-1:0]   tc_i,
  input logic             scan_start_i,
  input logic [2*NCH-1:0] status_o,
  input logic [NCH-1:0]   mask_o,
  input logic [DW-1:0]    command_o,
  input logic             ff_o,
  input logic [NCH-1:0]   svc_o,
  input logic             scan_busy_o,
  input logic             scan_reject_o,
  input logic             cmd_err_o
);

  // R2
  cmd_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_port_i == 3'd0 && wr_data_i != '0) |=> (cmd_err_o && $stable(command_o)));

  // R7
  mrst_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_port_i == 3'd5 && hold_i == '0 && tc_i == '0)
      |=> (mask_o == '1 && status_o == '0 && command_o == '0 && !ff_o));

  // R8
  clrmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_port_i == 3'd6) |=> (mask_o == '0));

  // R9
  release_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|release_i) |=> ((status_o[2*NCH-1:NCH] & $past(release_i)) == '0));

  // R10
  svc_in_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|svc_o) |-> $past(scan_busy_o));

  // R10
  svc_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|svc_o) |-> (($past(mask_o) & svc_o) == '0));

  // R11
  reentry_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_start_i && scan_busy_o) |=> scan_reject_o);

  // R12
  svc_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(svc_o));

endmodule

bind dmac_ctrl dmac_ctrl_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_port_i     (wr_port_i),
  .wr_data_i     (wr_data_i),
  .hold_i        (hold_i),
  .release_i     (release_i),
  .tc_i          (tc_i),
  .scan_start_i  (scan_start_i),
  .status_o      (status_o),
  .mask_o        (mask_o),
  .command_o     (command_o),
  .ff_o          (ff_o),
  .svc_o         (svc_o),
  .scan_busy_o   (scan_busy_o),
  .scan_reject_o (scan_reject_o),
  .cmd_err_o     (cmd_err_o)
);

// File: tb/dmac_ctrl_tb_top.sv
module dmac_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_port = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  hold = '0, rel = '0, tc = '0;
  logic        fft = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  status;
  logic [3:0]  mask;
  logic [7:0]  command;
  logic        ff;
  logic [31:0] mode;
  logic [3:0]  svc;
  logic        busy, reject, cerr;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dmac_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_port_i(wr_port),
    .wr_data_i(wr_data), .hold_i(hold), .release_i(rel), .tc_i(tc),
    .ff_toggle_i(fft), .scan_start_i(start), .status_o(status),
    .mask_o(mask), .command_o(command), .ff_o(ff), .mode_o(mode),
    .svc_o(svc), .scan_busy_o(busy), .scan_reject_o(reject), .cmd_err_o(cerr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic dev(input logic [3:0] h, input logic [3:0] r, input logic [3:0] t, input logic f);
    @(negedge clk);
    hold = h; rel = r; tc = t; fft = f;
    @(negedge clk);
    hold = '0; rel = '0; tc = '0; fft = 1'b0;
  endtask

  // full pass, strobes checked against the expected eligible set
  task automatic run_pass(input logic [3:0] elig, input string tag);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " busy at start"}, busy, 1);
    chk({tag, " no strobe before visit"}, svc, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk({tag, " strobe order"}, svc, elig[k] ? (32'd1 << k) : 0);
    end
    chk({tag, " busy ends"}, busy, 0);
  endtask

  task automatic test_reset();
    chk("R1 mask", mask, 4'hF);
    chk("R1 status", status, 0);
    chk("R1 command", command, 0);
    chk("R1 ff", ff, 0);
    chk("R1 mode", mode, 0);
    chk("R1 svc/busy", {svc, busy}, 0);
  endtask

  task automatic test_command();
    wr(3'd0, 8'h00);
    chk("R2 zero accepted err", cerr, 0);
    chk("R2 zero accepted cmd", command, 0);
    wr(3'd0, 8'h10);
    chk("R2 nonzero err pulse", cerr, 1);
    chk("R2 nonzero cmd kept", command, 0);
    @(negedge clk);
    chk("R2 err one cycle", cerr, 0);
  endtask

  task automatic test_device();
    dev(4'b0101, 4'b0000, 4'b0000, 1'b0);
    chk("R9 hold", status, 8'h50);
    dev(4'b0000, 4'b0000, 4'b0011, 1'b0);
    chk("R9 tc", status, 8'h53);
    dev(4'b0010, 4'b0010, 4'b0000, 1'b0);
    chk("R9 release wins", status, 8'h53);
    dev(4'b0000, 4'b0100, 4'b0000, 1'b0);
    chk("R9 release", status, 8'h13);
  endtask

  task automatic test_request();
    wr(3'd1, 8'b0000_0110);
    chk("R3 set ch2", status, 8'h53);
    wr(3'd1, 8'b0000_0001);
    chk("R3 clear ch1 tc", status, 8'h51);
    wr(3'd1, 8'b0000_0000);
    chk("R3 clear ch0 req and tc", status, 8'h40);
    wr(3'd1, 8'b0000_0100);
    chk("R3 set ch0", status, 8'h50);
  endtask

  task automatic test_smask();
    wr(3'd2, 8'b0000_0000);
    chk("R4 clear ch0", mask, 4'hE);
    wr(3'd2, 8'b0000_0010);
    chk("R4 clear ch2", mask, 4'hA);
    wr(3'd2, 8'b0000_0100);
    chk("R4 set ch0", mask, 4'hB);
    wr(3'd2, 8'b1111_1001);
    chk("R4 upper bits ignored", mask, 4'h9);
  endtask

  task automatic test_mode();
    wr(3'd3, 8'hA6);
    wr(3'd3, 8'h5B);
    chk("R5 mode bytes", mode, {8'h5B, 8'hA6, 8'h00, 8'h00});
  endtask

  task automatic test_ff();
    dev(4'b0, 4'b0, 4'b0, 1'b1);
    chk("R6 toggle", ff, 1);
    dev(4'b0, 4'b0, 4'b0, 1'b1);
    chk("R6 toggle back", ff, 0);
    dev(4'b0, 4'b0, 4'b0, 1'b1);
    wr(3'd4, 8'h00);
    chk("R6 clear", ff, 0);
    @(negedge clk);
    fft = 1'b1; wr_en = 1'b1; wr_port = 3'd4; wr_data = 8'h00;
    @(negedge clk);
    fft = 1'b0; wr_en = 1'b0;
    chk("R6 clear beats toggle", ff, 0);
  endtask

  task automatic test_masks();
    wr(3'd6, 8'hFF);
    chk("R8 clear all", mask, 4'h0);
    wr(3'd7, 8'hF5);
    chk("R8 write all", mask, 4'h5);
  endtask

  task automatic test_scan();
    dev(4'b1010, 4'b0000, 4'b0000, 1'b0);
    chk("R10 setup status", status[7:4], 4'hF);
    run_pass(4'b1010, "R10 partial");
    wr(3'd6, 8'h00);
    run_pass(4'b1111, "R10 ascending");
    wr(3'd7, 8'h0F);
    run_pass(4'b0000, "R10 all masked");
    wr(3'd6, 8'h00);
  endtask

  task automatic test_reentry();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R11 busy", busy, 1);
    @(negedge clk); start = 1'b1;
    chk("R12 svc ch0", svc, 4'b0001);
    @(negedge clk); start = 1'b0;
    chk("R11 reject pulse", reject, 1);
    chk("R11 pass continues ch1", svc, 4'b0010);
    @(negedge clk);
    chk("R11 reject one cycle", reject, 0);
    chk("R11 pass continues ch2", svc, 4'b0100);
    @(negedge clk);
    chk("R11 pass continues ch3", svc, 4'b1000);
    chk("R11 pass ends", busy, 0);
    run_pass(4'b1111, "R11 next start accepted");
  endtask

  task automatic test_mrst();
    dev(4'b0, 4'b0, 4'b0, 1'b1);
    wr(3'd5, 8'h00);
    chk("R7 mask", mask, 4'hF);
    chk("R7 status", status, 0);
    chk("R7 command", command, 0);
    chk("R7 ff", ff, 0);
    chk("R7 modes kept", mode, {8'h5B, 8'hA6, 8'h00, 8'h00});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_command();
    test_device();
    test_request();
    test_smask();
    test_mode();
    test_ff();
    test_masks();
    test_scan();
    test_reentry();
    test_mrst();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule